// File: doc/BRIEF.md
# Sticky Fault Collector with Single-Shot Level-1 Request

This block gathers five active-low fault signals into one sticky fault register and turns that register into a level-1 interrupt request for the interrupt logic. Three of the signals belong to the bus cycle: external address error, memory protect violation and parity error. Two are general purpose. Register bits are set only when the address strobe falls, and they stay set until software issues a read-and-clear command. A plain read command returns the register without disturbing it.

A parity error lands in one of three bits, chosen by the transfer type present when the strobe falls. The two general-purpose inputs are caught by holding latches as soon as they go low, so even a short pulse is kept until the next strobe fall moves it into the register. The interrupt request comes from the OR of all register bits and fires once, on the rise of that OR. While any bit remains set, later faults add bits but raise no new request. The interrupt system therefore sees nothing more until the handler clears the register to zero.

Everything is synchronous to one clock. The address strobe is an ordinary input, and a fall means it was high at the previous clock edge and is low at this one.

Top module: `fault_latch_reg`

## Requirements
- R1: After reset the fault register is zero, and `lvl1Req`, `rdValid` and `rdData` are all zero.
- R2: At a clock edge where `addrStrobeN` falls, a low `extAddrFaultN` sets register bit 0 and a low `memProtFaultN` sets bit 1. A low level at any other edge has no effect on the register.
- R3: At a strobe fall, a low `parityFaultN` sets a bit chosen by `xferType`: code 0 (memory) sets bit 2, code 1 (IO) sets bit 3, code 2 (DMA) sets bit 4, and code 3 is treated as memory and sets bit 2.
- R4: A low level on `gpFaultN[0]` or `gpFaultN[1]`, even for one clock while the strobe is high, is held. It sets bit 5 or bit 6 respectively at the next strobe fall and does not set it earlier.
- R5: A general-purpose holding latch empties once its content has been moved into the register. A later strobe fall with the input high does not set the bit again.
- R6: Register bits stay set across any number of strobe falls and plain reads. Only a read-and-clear removes them.
- R7: `readCmd` makes `rdValid` high for one cycle on the next clock, with `rdData` equal to the register at the command edge, and leaves the register unchanged.
- R8: `readClearCmd` returns the register in the same way as R7 and zeroes it. If a fault is set at the same edge, that new bit survives the clear. `readClearCmd` takes precedence when both commands are high.
- R9: `lvl1Req` is high for exactly one cycle, in the cycle after the register changes from zero to nonzero.
- R10: While the register is nonzero, further faults raise no `lvl1Req`. After a clear leaves the register at zero, the next fault raises `lvl1Req` again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addrStrobeN | input | 1 | Address strobe, active low; register bits are set on its falling edge |
| extAddrFaultN | input | 1 | External address fault, active low |
| memProtFaultN | input | 1 | Memory protect fault, active low |
| parityFaultN | input | 1 | Parity error, active low |
| gpFaultN | input | 2 | General-purpose faults, active low, held until sampled |
| xferType | input | 2 | Transfer type for parity routing: 0 memory, 1 IO, 2 DMA |
| readCmd | input | 1 | Non-destructive read request |
| readClearCmd | input | 1 | Read-and-clear request |
| rdData | output | 7 | Register value returned by the last read |
| rdValid | output | 1 | One-cycle flag that `rdData` was just loaded |
| lvl1Req | output | 1 | One-cycle level-1 interrupt request |

## Verification
The bench targets the following corner cases:

- **Short general-purpose pulse.** A pulse that ends well before the strobe falls must still reach the register. A design without holding latches would lose it. A design whose latch never empties would set the bit again after a clear.
- **Parity routing.** Every transfer code, including the reserved one, must pick the correct bit. A wrong mapping shows up in the read-back value.
- **Single-shot request.** A second fault while the register is nonzero must not raise the request again. A level-driven request would fire repeatedly, and a request that never re-arms would stay silent after a clear.
- **Clear and set in the same cycle.** The new fault must survive the clear, and no request may follow. A design that gives priority to the clear would drop the fault.

// File: rtl/fault_latch_pkg.sv
package fault_latch_pkg;
  localparam int GP_COUNT   = 2;
  localparam int FAULT_W    = 5 + GP_COUNT;
  localparam int XFER_W     = 2;

  // bit positions inside the fault register
  localparam int BIT_EXTADDR = 0;
  localparam int BIT_MEMPROT = 1;
  localparam int BIT_PAR_MEM = 2;
  localparam int BIT_PAR_IO  = 3;
  localparam int BIT_PAR_DMA = 4;
  localparam int BIT_GP_BASE = 5;

  typedef enum logic [XFER_W-1:0] {
    XFER_MEM  = 2'd0,
    XFER_IO   = 2'd1,
    XFER_DMA  = 2'd2,
    XFER_RSVD = 2'd3
  } xferKind_t;

  typedef logic [FAULT_W-1:0] faultVec_t;

  // strobes from control to datapath
  typedef struct packed {
    logic asFall;   // sample faults into the register
    logic clrReg;   // zero the register (new sets still win)
    logic rdLoad;   // copy register into the read buffer
  } ctrlStrobes_t;
endpackage

// File: rtl/fault_latch_ctrl.sv
module fault_latch_ctrl
  import fault_latch_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         addrStrobeN,
  input  logic         readCmd,
  input  logic         readClearCmd,
  input  logic         anyFault,
  output ctrlStrobes_t strobes,
  output logic         rdValid,
  output logic         lvl1Req
);
  logic asPrevHigh;
  logic anyFaultQ;

  // strobe history: reset to idle-high so a low strobe at release counts as a fall
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) asPrevHigh <= 1'b1;
    else       asPrevHigh <= addrStrobeN;
  end

  always_comb begin
    strobes.asFall = asPrevHigh & ~addrStrobeN;
    strobes.clrReg = readClearCmd;
    strobes.rdLoad = readCmd | readClearCmd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdValid <= 1'b0;
    else       rdValid <= strobes.rdLoad;
  end

  // anti-repeat: request only on the rise of the OR of all fault bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) anyFaultQ <= 1'b0;
    else       anyFaultQ <= anyFault;
  end

  assign lvl1Req = anyFault & ~anyFaultQ;
endmodule

// File: rtl/fault_latch_dp.sv
module fault_latch_dp
  import fault_latch_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic                extAddrFaultN,
  input  logic                memProtFaultN,
  input  logic                parityFaultN,
  input  logic [GP_COUNT-1:0] gpFaultN,
  input  logic [XFER_W-1:0]   xferType,
  output faultVec_t           faultReg,
  output faultVec_t           rdData,
  output logic                anyFault
);
  faultVec_t           setVec;
  faultVec_t           faultNext;
  logic [GP_COUNT-1:0] gpHold;
  logic [GP_COUNT-1:0] gpPending;
  logic [2:0]          parRoute;

  // holding latches for the general-purpose faults
  for (genvar g = 0; g < GP_COUNT; g++) begin : g_gpHold
    assign gpPending[g] = gpHold[g] | ~gpFaultN[g];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               gpHold[g] <= 1'b0;
      else if (strobes.asFall) gpHold[g] <= 1'b0;
      else if (!gpFaultN[g])   gpHold[g] <= 1'b1;
    end
  end

  // parity error steering by transfer type
  always_comb begin
    parRoute = 3'b000;
    unique case (xferKind_t'(xferType))
      XFER_IO:  parRoute = 3'b010;
      XFER_DMA: parRoute = 3'b100;
      default:  parRoute = 3'b001;
    endcase
  end

  always_comb begin
    setVec = '0;
    if (strobes.asFall) begin
      setVec[BIT_EXTADDR] = ~extAddrFaultN;
      setVec[BIT_MEMPROT] = ~memProtFaultN;
      setVec[BIT_PAR_MEM] = ~parityFaultN & parRoute[0];
      setVec[BIT_PAR_IO]  = ~parityFaultN & parRoute[1];
      setVec[BIT_PAR_DMA] = ~parityFaultN & parRoute[2];
      setVec[BIT_GP_BASE +: GP_COUNT] = gpPending;
    end
    faultNext = (strobes.clrReg ? '0 : faultReg) | setVec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) faultReg <= '0;
    else       faultReg <= faultNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               rdData <= '0;
    else if (strobes.rdLoad) rdData <= faultReg;
  end

  assign anyFault = |faultReg;
endmodule

// File: rtl/fault_latch_reg.sv
module fault_latch_reg
  import fault_latch_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                addrStrobeN,
  input  logic                extAddrFaultN,
  input  logic                memProtFaultN,
  input  logic                parityFaultN,
  input  logic [GP_COUNT-1:0] gpFaultN,
  input  logic [XFER_W-1:0]   xferType,
  input  logic                readCmd,
  input  logic                readClearCmd,
  output logic [FAULT_W-1:0]  rdData,
  output logic                rdValid,
  output logic                lvl1Req
);
  ctrlStrobes_t strobes;
  faultVec_t    faultReg;
  logic         anyFault;

  fault_latch_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .addrStrobeN(addrStrobeN),
    .readCmd(readCmd), .readClearCmd(readClearCmd),
    .anyFault(anyFault), .strobes(strobes),
    .rdValid(rdValid), .lvl1Req(lvl1Req)
  );

  fault_latch_dp i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .extAddrFaultN(extAddrFaultN), .memProtFaultN(memProtFaultN),
    .parityFaultN(parityFaultN), .gpFaultN(gpFaultN), .xferType(xferType),
    .faultReg(faultReg), .rdData(rdData), .anyFault(anyFault)
  );
endmodule

// File: rtl/fault_latch_chk.sv
module fault_latch_chk
  import fault_latch_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               addrStrobeN,
  input logic               readCmd,
  input logic               readClearCmd,
  input logic [FAULT_W-1:0] faultReg,
  input logic [FAULT_W-1:0] rdData,
  input logic               rdValid,
  input logic               lvl1Req
);
  // R6: bits never drop without a read-and-clear
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    !readClearCmd |=> ((faultReg & $past(faultReg)) == $past(faultReg)));

  // R2: no bit appears unless the strobe was high and is now low
  p_set_on_fall_r2: assert property (@(posedge clk) disable iff (!rstN)
    !($past(addrStrobeN) && !addrStrobeN) |=> ((faultReg & ~$past(faultReg)) == '0));

  // R7: read returns the register seen at the command edge
  p_read_data_r7: assert property (@(posedge clk) disable iff (!rstN)
    (readCmd || readClearCmd) |=> (rdValid && rdData == $past(faultReg)));

  // R9: request is a single-cycle pulse backed by a nonzero register
  p_req_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    lvl1Req |-> (faultReg != '0) ##1 !lvl1Req);

  // R10: no request while the register already held faults
  p_anti_repeat_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(faultReg) != '0) |-> !lvl1Req);
endmodule

bind fault_latch_reg fault_latch_chk i_chk (
  .clk(clk), .rstN(rstN), .addrStrobeN(addrStrobeN),
  .readCmd(readCmd), .readClearCmd(readClearCmd),
  .faultReg(faultReg), .rdData(rdData), .rdValid(rdValid), .lvl1Req(lvl1Req)
);

// File: tb/test_fault_latch_reg.sv
`timescale 1ns/1ps
module test_fault_latch_reg;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       addrStrobeN = 1'b1;
  logic       extAddrFaultN = 1'b1;
  logic       memProtFaultN = 1'b1;
  logic       parityFaultN = 1'b1;
  logic [1:0] gpFaultN = 2'b11;
  logic [1:0] xferType = 2'd0;
  logic       readCmd = 1'b0;
  logic       readClearCmd = 1'b0;
  logic [6:0] rdData;
  logic       rdValid;
  logic       lvl1Req;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fault_latch_reg i_fault_latch_reg (
    .clk(clk), .rstN(rstN), .addrStrobeN(addrStrobeN),
    .extAddrFaultN(extAddrFaultN), .memProtFaultN(memProtFaultN),
    .parityFaultN(parityFaultN), .gpFaultN(gpFaultN), .xferType(xferType),
    .readCmd(readCmd), .readClearCmd(readClearCmd),
    .rdData(rdData), .rdValid(rdValid), .lvl1Req(lvl1Req)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  // strobe pulse; samples lvl1Req in the cycle after the fall edge
  task automatic strobe(output logic req);
    @(negedge clk) addrStrobeN = 1'b0;
    @(negedge clk) req = lvl1Req;
    addrStrobeN = 1'b1;
    @(negedge clk);
  endtask

  task automatic readReg(input bit clr, output logic [6:0] val, output logic vld);
    @(negedge clk) begin readCmd = !clr; readClearCmd = clr; end
    @(negedge clk) begin val = rdData; vld = rdValid; readCmd = 1'b0; readClearCmd = 1'b0; end
  endtask

  task automatic clearAll();
    logic [6:0] v; logic k;
    readReg(1'b1, v, k);
  endtask

  task automatic tReset();
    check("R1 rdData", {1'b0, rdData}, 8'h00);
    check("R1 rdValid", {7'b0, rdValid}, 8'h00);
    check("R1 lvl1Req", {7'b0, lvl1Req}, 8'h00);
    begin logic [6:0] v; logic k; readReg(1'b0, v, k); check("R1 reg", {1'b0, v}, 8'h00); end
  endtask

  task automatic tBusFaults();
    logic r; logic [6:0] v; logic k;
    // low while strobe steady: ignored
    @(negedge clk) extAddrFaultN = 1'b0;
    repeat (3) @(negedge clk);
    extAddrFaultN = 1'b1;
    readReg(1'b0, v, k);
    check("R2 no fall ignored", {1'b0, v}, 8'h00);
    extAddrFaultN = 1'b0;
    strobe(r);
    extAddrFaultN = 1'b1;
    check("R9 first pulse", {7'b0, r}, 8'h01);
    check("R9 pulse one cycle", {7'b0, lvl1Req}, 8'h00);
    memProtFaultN = 1'b0;
    strobe(r);
    memProtFaultN = 1'b1;
    check("R10 no repeat", {7'b0, r}, 8'h00);
    readReg(1'b0, v, k);
    check("R2 bits", {1'b0, v}, 8'h03);
    check("R7 valid", {7'b0, k}, 8'h01);
    readReg(1'b0, v, k);
    check("R7 non-destructive", {1'b0, v}, 8'h03);
    strobe(r);
    readReg(1'b1, v, k);
    check("R6 sticky / R8 returns", {1'b0, v}, 8'h03);
    readReg(1'b0, v, k);
    check("R8 cleared", {1'b0, v}, 8'h00);
  endtask

  task automatic tParity();
    logic r; logic [6:0] v; logic k;
    logic [6:0] exp [4] = '{7'h04, 7'h08, 7'h10, 7'h04};
    for (int t = 0; t < 4; t++) begin
      xferType = 2'(t);
      parityFaultN = 1'b0;
      strobe(r);
      parityFaultN = 1'b1;
      check("R10 re-armed after clear", {7'b0, r}, 8'h01);
      readReg(1'b1, v, k);
      check("R3 parity route", {1'b0, v}, {1'b0, exp[t]});
    end
    xferType = 2'd0;
  endtask

  task automatic tGp();
    logic r; logic [6:0] v; logic k;
    @(negedge clk) gpFaultN = 2'b10;
    @(negedge clk) gpFaultN = 2'b11;
    repeat (2) @(negedge clk);
    readReg(1'b0, v, k);
    check("R4 not before fall", {1'b0, v}, 8'h00);
    strobe(r);
    readReg(1'b0, v, k);
    check("R4 gp0 held", {1'b0, v}, 8'h20);
    check("R9 gp pulse", {7'b0, r}, 8'h01);
    clearAll();
    strobe(r);
    readReg(1'b0, v, k);
    check("R5 latch emptied", {1'b0, v}, 8'h00);
    @(negedge clk) gpFaultN = 2'b01;
    @(negedge clk) gpFaultN = 2'b11;
    strobe(r);
    readReg(1'b1, v, k);
    check("R4 gp1 held", {1'b0, v}, 8'h40);
  endtask

  task automatic tClearRace();
    logic r; logic [6:0] v; logic k;
    memProtFaultN = 1'b0;
    strobe(r);
    memProtFaultN = 1'b1;
    // clear and a new fault at the same edge
    @(negedge clk) begin addrStrobeN = 1'b0; extAddrFaultN = 1'b0; readClearCmd = 1'b1; readCmd = 1'b1; end
    @(negedge clk) begin
      check("R8 clear returns old", {1'b0, rdData}, 8'h02);
      check("R10 no pulse across race", {7'b0, lvl1Req}, 8'h00);
      addrStrobeN = 1'b1; extAddrFaultN = 1'b1; readClearCmd = 1'b0; readCmd = 1'b0;
    end
    readReg(1'b1, v, k);
    check("R8 set wins over clear", {1'b0, v}, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tBusFaults();
    tParity();
    tGp();
    tClearRace();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule